// File: doc/BRIEF.md
# External Pin Trigger Mode Selector

This block sits between a set of external interrupt pins and the interrupt controller. Every pin owns a small trigger-mode field. The field selects whether the pin raises a request while it is held low, while it is held high, or for one cycle when it falls, rises or changes in either direction. Each pin first crosses into the clock domain through a synchroniser chain. A per-pin evaluator then compares the synchronised level with its value one cycle earlier and produces the request.

Software reaches the mode fields through 32-bit configuration words. Each word holds eight pins, and each pin sits in its own 4-bit slot. The write port has a per-slot enable, so a write can change one pin's mode without a read-modify-write sequence and without disturbing the other seven pins. The read port is combinational on the word index.

Top module: `pin_trigger_sel`

## Requirements
- R1: The field of pin n is held in configuration word n/8, at bits 4*(n%8)+2 down to 4*(n%8).
- R2: Field codes: 000 is low level, 001 is high level, 010 and 011 are falling edge, 100 and 101 are rising edge, 110 and 111 are both edges. The low bit has no effect in the edge codes.
- R3: Bit 4*k+3 of every configuration word always reads as 0, even after a 1 is written there.
- R4: A write updates only the slots whose bit k in `cfg_slot_en` is 1. Every slot whose enable bit is 0 keeps its old value. When `cfg_slot_en` is zero the write changes nothing.
- R5: Reset is synchronous and active high. It clears every field to 000 (low-level mode), so all configuration words read 0 afterwards.
- R6: With the default two synchroniser stages, a pin level sampled at clock edge E first affects `irq_req` after edge E+1. After edge E it has no effect yet.
- R7: In a level mode, `irq_req` stays high for as long as the synchronised pin is at the selected level, and stays low otherwise.
- R8: In the falling-edge or rising-edge mode, `irq_req` is high for exactly one cycle after the matching transition reaches the synchroniser output. The opposite transition produces no request.
- R9: In the both-edges mode, every transition of the synchronised pin produces a one-cycle request.
- R10: `cfg_rdata` shows the word selected by `cfg_addr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous external pin levels |
| cfg_addr | input | ADDR_W | Configuration word index for read and write |
| cfg_wr | input | 1 | Write strobe |
| cfg_slot_en | input | 8 | Per-slot write enable, bit k covers bits 4k+3..4k |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected configuration word |
| irq_req | output | NUM_PINS | Per-pin request to the interrupt controller |

## Verification
The checker covers the configuration path on every cycle:
- the spare bit of each slot stays zero;
- slots with a clear enable bit hold their value across a write;
- enabled slots take the write data;
- the read word holds steady when there is no write and no change of index;
- an edge-mode request never lasts two cycles unless the mode changed.

Other properties need a known pin history, so only the bench scenarios can show them:
- the exact synchroniser latency;
- level requests that persist;
- the absence of a request on the opposite edge;
- that the low bit of an edge code has no effect.

// File: rtl/pin_trig_pkg.sv
package pin_trig_pkg;

    localparam int REG_W         = 32;
    localparam int FIELD_W       = 3;
    localparam int SLOT_W        = 4;
    localparam int SLOTS_PER_REG = REG_W / SLOT_W;

    typedef enum logic [2:0] {
        TM_LOW,
        TM_HIGH,
        TM_FALL,
        TM_RISE,
        TM_BOTH
    } trig_mode_e;

    typedef struct packed {
        logic now;
        logic prev;
    } pin_hist_t;

    function automatic trig_mode_e decode_mode(input logic [FIELD_W-1:0] f);
        trig_mode_e m;
        case (f[2:1])
            2'b00:   m = f[0] ? TM_HIGH : TM_LOW;
            2'b01:   m = TM_FALL;
            2'b10:   m = TM_RISE;
            default: m = TM_BOTH;
        endcase
        return m;
    endfunction

    function automatic logic fire(input trig_mode_e m, input pin_hist_t h);
        logic r;
        case (m)
            TM_LOW:  r = ~h.now;
            TM_HIGH: r = h.now;
            TM_FALL: r = h.prev & ~h.now;
            TM_RISE: r = ~h.prev & h.now;
            TM_BOTH: r = h.prev ^ h.now;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Expand per-slot enables into a 32-bit mask of whole slots.
    function automatic logic [REG_W-1:0] slot_mask(input logic [SLOTS_PER_REG-1:0] en);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < SLOTS_PER_REG; i++)
            if (en[i]) m[i*SLOT_W +: SLOT_W] = '1;
        return m;
    endfunction

    // Field bits of the slots in word reg_idx that map to existing pins.
    function automatic logic [REG_W-1:0] live_fields(input int reg_idx, input int num_pins);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < SLOTS_PER_REG; i++)
            if (reg_idx * SLOTS_PER_REG + i < num_pins) m[i*SLOT_W +: FIELD_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] now_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pin_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[STAGES-1];
    end

    assign now_o  = chain[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank import pin_trig_pkg::*; #(
    parameter int NUM_PINS = 16,
    parameter int NUM_REGS = 2,
    parameter int ADDR_W   = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              wr_i,
    input  logic [SLOTS_PER_REG-1:0]          slot_en_i,
    input  logic [REG_W-1:0]                  wdata_i,
    output logic [REG_W-1:0]                  rdata_o,
    output logic [NUM_PINS-1:0][FIELD_W-1:0]  fields_o
);
    localparam int PADDED = NUM_REGS * SLOTS_PER_REG;

    logic [FIELD_W-1:0] fld_q  [NUM_PINS];
    logic [FIELD_W-1:0] padded [PADDED];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
        localparam int REG_IDX = p / SLOTS_PER_REG;
        localparam int SLOT    = p % SLOTS_PER_REG;
        always_ff @(posedge clk) begin
            if (rst)
                fld_q[p] <= '0;
            else if (wr_i && (addr_i == ADDR_W'(REG_IDX)) && slot_en_i[SLOT])
                fld_q[p] <= wdata_i[SLOT*SLOT_W +: FIELD_W];
        end
        assign fields_o[p] = fld_q[p];
    end

    for (genvar s = 0; s < PADDED; s++) begin : g_pad
        if (s < NUM_PINS) begin : g_live
            assign padded[s] = fld_q[s];
        end else begin : g_none
            assign padded[s] = '0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(addr_i) < NUM_REGS)
            for (int i = 0; i < SLOTS_PER_REG; i++)
                rdata_o[i*SLOT_W +: FIELD_W] = padded[int'(addr_i)*SLOTS_PER_REG + i];
    end
endmodule

// File: rtl/trig_eval.sv
module trig_eval import pin_trig_pkg::*; #(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0][FIELD_W-1:0] fields_i,
    input  logic [NUM_PINS-1:0]              now_i,
    input  logic [NUM_PINS-1:0]              prev_i,
    output logic [NUM_PINS-1:0]              req_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_hist_t  hist;
        trig_mode_e mode;
        assign hist     = '{now: now_i[p], prev: prev_i[p]};
        assign mode     = decode_mode(fields_i[p]);
        assign req_o[p] = fire(mode, hist);
    end
endmodule

// File: rtl/pin_trigger_sel.sv
module pin_trigger_sel import pin_trig_pkg::*; #(
    parameter  int NUM_PINS    = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int NUM_REGS    = (NUM_PINS + SLOTS_PER_REG - 1) / SLOTS_PER_REG,
    localparam int ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_PINS-1:0]      pin_in,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic                     cfg_wr,
    input  logic [SLOTS_PER_REG-1:0] cfg_slot_en,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic [REG_W-1:0]         cfg_rdata,
    output logic [NUM_PINS-1:0]      irq_req
);
    logic [NUM_PINS-1:0][FIELD_W-1:0] pin_field;
    logic [NUM_PINS-1:0]              sync_now;
    logic [NUM_PINS-1:0]              sync_prev;

    trig_cfg_bank #(.NUM_PINS(NUM_PINS), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (cfg_addr),
        .wr_i      (cfg_wr),
        .slot_en_i (cfg_slot_en),
        .wdata_i   (cfg_wdata),
        .rdata_o   (cfg_rdata),
        .fields_o  (pin_field)
    );

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in),
        .now_o  (sync_now),
        .prev_o (sync_prev)
    );

    trig_eval #(.NUM_PINS(NUM_PINS)) u_eval (
        .fields_i (pin_field),
        .now_i    (sync_now),
        .prev_i   (sync_prev),
        .req_o    (irq_req)
    );
endmodule

// File: rtl/pin_trigger_sel_chk.sv
module pin_trigger_sel_chk import pin_trig_pkg::*; #(
    parameter int NUM_PINS = 16,
    parameter int ADDR_W   = 1
) (
    input logic                             clk,
    input logic                             rst,
    input logic [ADDR_W-1:0]                cfg_addr,
    input logic                             cfg_wr,
    input logic [SLOTS_PER_REG-1:0]         cfg_slot_en,
    input logic [REG_W-1:0]                 cfg_wdata,
    input logic [REG_W-1:0]                 cfg_rdata,
    input logic [NUM_PINS-1:0]              irq_req,
    input logic [NUM_PINS-1:0][FIELD_W-1:0] pin_field
);
    localparam logic [REG_W-1:0] SPARE_BITS = ~slot_mask('1) | {SLOTS_PER_REG{4'b1000}};

    assert_spare_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & SPARE_BITS) == '0);

    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cfg_rdata == '0);

    assert_masked_hold_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_addr != $past(cfg_addr)) ||
                   (((cfg_rdata ^ $past(cfg_rdata)) & ~slot_mask($past(cfg_slot_en))) == '0));

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_addr != $past(cfg_addr)) ||
                   ((cfg_rdata & slot_mask($past(cfg_slot_en)) & live_fields(int'($past(cfg_addr)), NUM_PINS)) ==
                    ($past(cfg_wdata) & slot_mask($past(cfg_slot_en)) & live_fields(int'($past(cfg_addr)), NUM_PINS))));

    assert_read_steady_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_rdata)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
            (irq_req[p] && (pin_field[p][2:1] == 2'b01 || pin_field[p][2:1] == 2'b10))
            |=> !irq_req[p] || (pin_field[p] != $past(pin_field[p])));
    end
endmodule

bind pin_trigger_sel pin_trigger_sel_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_addr    (cfg_addr),
    .cfg_wr      (cfg_wr),
    .cfg_slot_en (cfg_slot_en),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .irq_req     (irq_req),
    .pin_field   (pin_field)
);

// File: tb/pin_trigger_sel_bench.sv
module pin_trigger_sel_bench;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic [0:0]    cfg_addr = '0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_slot_en = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NP-1:0] irq_req;

    int applied = 0;
    int bad     = 0;
    logic [2:0] shadow [NP];

    always #4 clk = ~clk;

    pin_trigger_sel u_pin_trigger_sel (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_slot_en(cfg_slot_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req)
    );

    // {mode[2:0], pin[3:0], lv0, lv1, exp_before, exp_pulse_cycle, exp_after, 4'h0}
    localparam logic [15:0] VEC [12] = '{
        {3'b000, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0},  // R7 low level
        {3'b001, 4'd1,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0},  // R7 high level
        {3'b001, 4'd1,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0},  // R7 high released
        {3'b010, 4'd2,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0},  // R8 falling
        {3'b011, 4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0},  // R8 R2 falling code, rise ignored
        {3'b100, 4'd9,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0},  // R8 rising
        {3'b101, 4'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0},  // R8 R2 rising code, fall ignored
        {3'b110, 4'd15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0},  // R9 both, rise
        {3'b111, 4'd15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0},  // R9 both, fall
        {3'b000, 4'd8,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0},  // R7 low released
        {3'b010, 4'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0},  // R1 top slot
        {3'b100, 4'd14, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0}   // R1 word 1 slot 6
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input int a, input logic [7:0] en, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = 1'(a); cfg_slot_en = en; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_slot_en = '0;
        for (int k = 0; k < 8; k++)
            if (en[k] && a*8 + k < NP) shadow[a*8 + k] = d[k*4 +: 3];
    endtask

    task automatic expect_word(input int a, input string req);
        logic [31:0] e;
        e = '0;
        for (int k = 0; k < 8; k++)
            if (a*8 + k < NP) e[k*4 +: 3] = shadow[a*8 + k];
        cfg_addr = 1'(a);
        #1;
        check(cfg_rdata == e, req, cfg_rdata, e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        applied++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_word(0, "R5");
        expect_word(1, "R5");
        check(irq_req == '1, "R5 low-level default", 32'(irq_req), 32'hFFFF);

        // table walk
        for (int v = 0; v < 12; v++) begin
            logic [2:0] md; int pn; logic l0, l1, e0, e1, e2;
            md = VEC[v][15:13]; pn = int'(VEC[v][12:9]);
            l0 = VEC[v][8]; l1 = VEC[v][7]; e0 = VEC[v][6]; e1 = VEC[v][5]; e2 = VEC[v][4];
            write_word(pn / 8, 8'(1 << (pn % 8)), 32'(md) << (4 * (pn % 8)));
            pin_in[pn] = l0;
            repeat (4) @(negedge clk);
            check(irq_req[pn] == e0, "R7 R8 settled", 32'(irq_req[pn]), 32'(e0));
            pin_in[pn] = l1;
            @(negedge clk);
            check(irq_req[pn] == e0, "R6 one edge", 32'(irq_req[pn]), 32'(e0));
            @(negedge clk);
            check(irq_req[pn] == e1, "R6 R7 R8 R9 two edges", 32'(irq_req[pn]), 32'(e1));
            @(negedge clk);
            check(irq_req[pn] == e2, "R7 R8 R9 three edges", 32'(irq_req[pn]), 32'(e2));
        end
        expect_word(1, "R1");

        // directed: spare bits, slot isolation, immediate read
        write_word(0, 8'hFF, 32'hFFFF_FFFF);
        expect_word(0, "R3");
        @(negedge clk);
        check(irq_req[7:0] == 8'h00, "R2 both-edge idle", 32'(irq_req[7:0]), 32'h0);
        write_word(0, 8'h04, 32'h0000_0000);
        expect_word(0, "R4 one slot");
        check(cfg_rdata == 32'h7777_7077, "R4 literal", cfg_rdata, 32'h7777_7077);
        write_word(0, 8'h00, 32'h0000_0000);
        expect_word(0, "R4 no enable");
        expect_word(1, "R10 index switch");
        expect_word(0, "R10 index back");

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule